// File: doc/BRIEF.md
# Bulk Bitwise Row Operation Engine

This block models a compute subarray that works on whole rows at a time. It holds a small set of wide data rows. It also holds three scratch rows used for majority evaluation, two constant rows (all zeros and all ones) and one complement row with a dual contact. A row-wide sense buffer sits beside them. Every operation touches all bit positions of a row in the same step.

A host sends one command at a time over a valid/ready handshake. The available commands are:

- row read and row write
- row copy
- row negation
- bitwise AND and OR of two rows
- three-input bitwise majority

An internal sequencer turns each command into an ordered list of primitive steps and runs one step per clock. There are three primitive kinds:

- An in-array copy, which moves a row through the sense buffer.
- A triple activation of the scratch rows, which leaves their bitwise majority in all three scratch rows and in the buffer.
- A complement copy out of the dual-contact row.

AND is a majority with the zero row as the third input, and OR is a majority with the ones row. The operands are always copied into the scratch rows first, so the source rows stay intact. A one-cycle done pulse marks the end of each command. The sense buffer is visible on the read-data port.

Top module: `bbr_engine`

## Requirements
- R1: After reset every data row reads as zero, `cmd_ready_o` is 1, `done_o` is 0 and `rdata_o` is zero.
- R2: A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` stays 0 until the command finishes. `done_o` is a single-cycle pulse, and `cmd_ready_o` is 1 in that same cycle.
- R3: Counted from the accepting edge, `done_o` rises after 1 clock edge for read, write, copy and the spare code, after 2 for NOT, and after 5 for AND, OR and MAJ.
- R4: Op code 1 (write) stores `cmd_wdata_i` into row `cmd_dst_i`. Op code 0 (read) places row `cmd_src_a_i` on `rdata_o`.
- R5: Op code 2 (copy) makes row dst equal to row src_a.
- R6: Op code 3 (NOT) makes row dst equal to the bitwise complement of row src_a.
- R7: Op code 4 (AND) makes row dst equal to src_a AND src_b.
- R8: Op code 5 (OR) makes row dst equal to src_a OR src_b.
- R9: Op code 6 (MAJ) makes row dst equal to the bitwise majority of src_a, src_b and src_c. After the triple activation, all three scratch rows and the buffer hold the same value.
- R10: No command changes any data row other than its dst. The result is correct when dst is the same row as one of the sources.
- R11: Op code 7 changes no row and leaves `rdata_o` unchanged.
- R12: After every command except op code 7, `rdata_o` holds the command's result row. For a read, that is the row that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_op_i | input | 3 | Op code (0 read, 1 write, 2 copy, 3 NOT, 4 AND, 5 OR, 6 MAJ, 7 spare) |
| cmd_dst_i | input | RAW | Destination data row |
| cmd_src_a_i | input | RAW | First source row |
| cmd_src_b_i | input | RAW | Second source row |
| cmd_src_c_i | input | RAW | Third source row (MAJ only) |
| cmd_wdata_i | input | ROW_W | Write data |
| done_o | output | 1 | One-cycle pulse at command completion |
| rdata_o | output | ROW_W | Row sense buffer contents |

## Verification
The bench sweeps every ordered pair of source rows and rotates through the compute op codes. It places the destination so that it sometimes coincides with a source. A design that wrote a scratch row back before the final copy, or that activated the operands in place, would corrupt a source or its own result; the bench catches this with full row read-backs. Constant-row mix-ups, such as using the ones row for AND, show up as wrong bits on rows with mixed content. The bench counts cycles to done against the step count for each op, so a sequence that skips or repeats a primitive is reported. The spare code is checked for leaving both the rows and the buffer unchanged.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int RA_W = 8;
  typedef logic [RA_W-1:0] raddr_t;

  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_WRITE = 3'd1, OP_COPY = 3'd2, OP_NOT = 3'd3,
    OP_AND  = 3'd4, OP_OR    = 3'd5, OP_MAJ  = 3'd6, OP_NOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    PR_NONE, PR_COPY, PR_TRA, PR_NCOPY, PR_RD, PR_WR
  } prim_e;

  typedef struct packed {
    prim_e  kind;
    raddr_t src;
    raddr_t dst;
  } prim_t;

  function automatic logic [2:0] op_steps(op_e op);
    case (op)
      OP_NOT:                 return 3'd2;
      OP_AND, OP_OR, OP_MAJ:  return 3'd5;
      default:                return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/bbr_seq.sv
module bbr_seq
  import bbr_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int N_ROWS = 8,
  localparam int RAW   = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [RAW-1:0]   cmd_dst_i,
  input  logic [RAW-1:0]   cmd_src_a_i,
  input  logic [RAW-1:0]   cmd_src_b_i,
  input  logic [RAW-1:0]   cmd_src_c_i,
  input  logic [ROW_W-1:0] cmd_wdata_i,
  output logic             ready_o,
  output logic             done_o,
  output prim_t            prim_o,
  output logic [ROW_W-1:0] wdata_o
);
  localparam int T0 = N_ROWS;
  localparam int T1 = N_ROWS + 1;
  localparam int T2 = N_ROWS + 2;
  localparam int DC = N_ROWS + 3;
  localparam int CZ = N_ROWS + 4;
  localparam int CO = N_ROWS + 5;

  logic           busy_q, done_q;
  logic [2:0]     step_q;
  op_e            op_q;
  logic [RAW-1:0] dst_q, a_q, b_q, c_q;
  logic [ROW_W-1:0] wd_q;
  logic           accept, last;

  assign accept  = cmd_valid_i & ~busy_q;
  assign last    = (step_q == op_steps(op_q) - 3'd1);
  assign ready_o = ~busy_q;
  assign done_o  = done_q;
  assign wdata_o = wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_NOP;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      wd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= op_e'(cmd_op_i);
        dst_q  <= cmd_dst_i;
        a_q    <= cmd_src_a_i;
        b_q    <= cmd_src_b_i;
        c_q    <= cmd_src_c_i;
        wd_q   <= cmd_wdata_i;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end

  // expand the latched command into the primitive of the current step
  always_comb begin
    prim_o = '{kind: PR_NONE, src: '0, dst: '0};
    if (busy_q) begin
      case (op_q)
        OP_READ:  prim_o = '{kind: PR_RD, src: raddr_t'(a_q), dst: '0};
        OP_WRITE: prim_o = '{kind: PR_WR, src: '0, dst: raddr_t'(dst_q)};
        OP_COPY:  prim_o = '{kind: PR_COPY, src: raddr_t'(a_q), dst: raddr_t'(dst_q)};
        OP_NOT:
          if (step_q == 3'd0) prim_o = '{kind: PR_COPY, src: raddr_t'(a_q), dst: raddr_t'(DC)};
          else                prim_o = '{kind: PR_NCOPY, src: raddr_t'(DC), dst: raddr_t'(dst_q)};
        OP_AND, OP_OR, OP_MAJ:
          case (step_q)
            3'd0: prim_o = '{kind: PR_COPY, src: raddr_t'(a_q), dst: raddr_t'(T0)};
            3'd1: prim_o = '{kind: PR_COPY, src: raddr_t'(b_q), dst: raddr_t'(T1)};
            3'd2: prim_o = '{kind: PR_COPY,
                             src: (op_q == OP_AND) ? raddr_t'(CZ) :
                                  (op_q == OP_OR)  ? raddr_t'(CO) : raddr_t'(c_q),
                             dst: raddr_t'(T2)};
            3'd3: prim_o = '{kind: PR_TRA, src: '0, dst: '0};
            default: prim_o = '{kind: PR_COPY, src: raddr_t'(T0), dst: raddr_t'(dst_q)};
          endcase
        default: prim_o = '{kind: PR_NONE, src: '0, dst: '0};
      endcase
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o) |=> !ready_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (step_q < op_steps(op_q)));
endmodule

// File: rtl/bbr_array.sv
module bbr_array
  import bbr_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int N_ROWS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  prim_t            prim_i,
  input  logic [ROW_W-1:0] wdata_i,
  output logic [ROW_W-1:0] rbuf_o
);
  localparam int N_TOT = N_ROWS + 4;
  localparam int IW    = $clog2(N_TOT);
  localparam int T0 = N_ROWS;
  localparam int T1 = N_ROWS + 1;
  localparam int T2 = N_ROWS + 2;
  localparam int DC = N_ROWS + 3;
  localparam int CZ = N_ROWS + 4;
  localparam int CO = N_ROWS + 5;

  logic [ROW_W-1:0] mem [N_TOT];
  logic [ROW_W-1:0] rbuf_q, src_row, maj_row, dcc_row, t0_row, t1_row, t2_row;
  logic [IW-1:0]    src_ix, dst_ix;

  assign src_ix  = prim_i.src[IW-1:0];
  assign dst_ix  = prim_i.dst[IW-1:0];
  assign t0_row  = mem[T0];
  assign t1_row  = mem[T1];
  assign t2_row  = mem[T2];
  assign dcc_row = mem[DC];
  assign maj_row = (t0_row & t1_row) | (t0_row & t2_row) | (t1_row & t2_row);
  assign rbuf_o  = rbuf_q;

  // constant rows are hardwired, never stored
  always_comb begin
    if (prim_i.src == raddr_t'(CZ))      src_row = '0;
    else if (prim_i.src == raddr_t'(CO)) src_row = '1;
    else                                 src_row = mem[src_ix];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TOT; i++) mem[i] <= '0;
      rbuf_q <= '0;
    end else begin
      case (prim_i.kind)
        PR_COPY: begin
          mem[dst_ix] <= src_row;
          rbuf_q      <= src_row;
        end
        PR_TRA: begin
          mem[T0] <= maj_row;
          mem[T1] <= maj_row;
          mem[T2] <= maj_row;
          rbuf_q  <= maj_row;
        end
        PR_NCOPY: begin
          mem[dst_ix] <= ~dcc_row;
          rbuf_q      <= ~dcc_row;
        end
        PR_RD: rbuf_q <= src_row;
        PR_WR: begin
          mem[dst_ix] <= wdata_i;
          rbuf_q      <= wdata_i;
        end
        default: ;
      endcase
    end
  end

  // R9
  tra_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_i.kind == PR_TRA) |=> (t0_row == t1_row && t1_row == t2_row && t0_row == rbuf_q));

  // R5
  copy_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_i.kind == PR_COPY) |=> (mem[$past(dst_ix)] == rbuf_q));

  // R6
  ncopy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_i.kind == PR_NCOPY) |=> (rbuf_q == ~$past(dcc_row)));
endmodule

// File: rtl/bbr_engine.sv
module bbr_engine
  import bbr_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int N_ROWS = 8,
  localparam int RAW   = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_op_i,
  input  logic [RAW-1:0]   cmd_dst_i,
  input  logic [RAW-1:0]   cmd_src_a_i,
  input  logic [RAW-1:0]   cmd_src_b_i,
  input  logic [RAW-1:0]   cmd_src_c_i,
  input  logic [ROW_W-1:0] cmd_wdata_i,
  output logic             done_o,
  output logic [ROW_W-1:0] rdata_o
);
  prim_t            prim;
  logic [ROW_W-1:0] wdata;

  bbr_seq #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_dst_i   (cmd_dst_i),
    .cmd_src_a_i (cmd_src_a_i),
    .cmd_src_b_i (cmd_src_b_i),
    .cmd_src_c_i (cmd_src_c_i),
    .cmd_wdata_i (cmd_wdata_i),
    .ready_o     (cmd_ready_o),
    .done_o      (done_o),
    .prim_o      (prim),
    .wdata_o     (wdata)
  );

  bbr_array #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prim_i  (prim),
    .wdata_i (wdata),
    .rbuf_o  (rdata_o)
  );
endmodule

// File: tb/sim_bbr_engine.sv
module sim_bbr_engine;
  localparam int CLK_P  = 10;
  localparam int W      = 16;
  localparam int NR     = 8;
  localparam int RAW    = $clog2(NR);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid = 1'b0;
  logic           ready, done;
  logic [2:0]     op = '0;
  logic [RAW-1:0] dst = '0, sa = '0, sb = '0, sc = '0;
  logic [W-1:0]   wd = '0, rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] ref_rows [NR];
  logic [W-1:0] exp_buf = '0;

  always #(CLK_P/2) clk = ~clk;

  bbr_engine #(.ROW_W(W), .N_ROWS(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_op_i(op), .cmd_dst_i(dst), .cmd_src_a_i(sa), .cmd_src_b_i(sb),
    .cmd_src_c_i(sc), .cmd_wdata_i(wd), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string req_of(int o);
    case (o)
      0: return "R4";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic do_op(input int o, input int d, input int a, input int b, input int c,
                       input logic [W-1:0] w, input string tag);
    logic [W-1:0] expv;
    int lat, cnt;
    bit seen;
    case (o)
      0: begin expv = ref_rows[a]; lat = 1; end
      1: begin expv = w; lat = 1; end
      2: begin expv = ref_rows[a]; lat = 1; end
      3: begin expv = ~ref_rows[a]; lat = 2; end
      4: begin expv = ref_rows[a] & ref_rows[b]; lat = 5; end
      5: begin expv = ref_rows[a] | ref_rows[b]; lat = 5; end
      6: begin expv = (ref_rows[a] & ref_rows[b]) | (ref_rows[a] & ref_rows[c]) |
                      (ref_rows[b] & ref_rows[c]); lat = 5; end
      default: begin expv = exp_buf; lat = 1; end
    endcase
    @(negedge clk);
    op = 3'(o); dst = RAW'(d); sa = RAW'(a); sb = RAW'(b); sc = RAW'(c); wd = w;
    valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
    cnt = 0; seen = 0;
    while (!seen && cnt < 20) begin
      @(negedge clk);
      cnt++;
      if (done) seen = 1;
      else if (ready !== 1'b0) chk(1'b0, "R2 ready while busy", W'(ready), '0);
    end
    // R3: done seen at the negedge following edge (accept + lat)
    chk(cnt - 1 == lat, "R3 latency", W'(cnt - 1), W'(lat));
    // R2
    chk(ready === 1'b1, "R2 ready at done", W'(ready), W'(1));
    // R12 / per-op result in the buffer
    chk(rdata === expv, (o == 7) ? "R11 buffer" : {req_of(o), " R12 ", tag}, rdata, expv);
    if (o >= 1 && o <= 6) ref_rows[d] = expv;
    exp_buf = expv;
    @(negedge clk);
    // R2: single-cycle pulse
    chk(done === 1'b0, "R2 pulse width", W'(done), '0);
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < NR; i++) do_op(0, 0, i, 0, 0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) ref_rows[i] = '0;
    #(CLK_P * 3);
    // R1
    chk(ready === 1'b1, "R1 ready", W'(ready), W'(1));
    chk(done === 1'b0, "R1 done", W'(done), '0);
    chk(rdata === '0, "R1 rdata", rdata, '0);
    @(negedge clk) rst_n = 1'b1;
    verify_all("R1");

    for (int i = 0; i < NR; i++) do_op(1, i, 0, 0, 0, W'($urandom), "R4");
    verify_all("R4");

    // constant-row corner cases
    do_op(1, 0, 0, 0, 0, '1, "R4");
    do_op(1, 1, 0, 0, 0, '0, "R4");
    do_op(4, 2, 0, 1, 0, '0, "R7");
    do_op(5, 3, 0, 1, 0, '0, "R8");
    do_op(4, 4, 0, 0, 0, '0, "R7");
    do_op(5, 5, 1, 1, 0, '0, "R8");
    do_op(3, 6, 1, 0, 0, '0, "R6");
    verify_all("R10");

    for (int a = 0; a < NR; a++) begin
      for (int b = 0; b < NR; b++) begin
        do_op(2 + ((a * NR + b) % 5), (a + 2 * b) % NR, a, b, (a + b + 3) % NR, '0, "R10");
      end
      verify_all("R10");
      do_op(1, a, 0, 0, 0, W'($urandom), "R4");
      do_op(1, (a + 5) % NR, 0, 0, 0, W'($urandom), "R4");
    end

    // R11: spare code changes neither rows nor buffer
    do_op(0, 0, 3, 0, 0, '0, "R4");
    do_op(7, 2, 5, 6, 7, W'($urandom), "R11");
    verify_all("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule